// File: doc/BRIEF.md
# Run-time Selectable Delay Line

This block is a serial-in, serial-out delay line of up to 16 stages, one data lane per bit of a configurable width. Each lane shifts on every clock edge at which the shift enable is high. A small select code picks the stage that drives the output, and the delay in enabled cycles is the code plus one. The code can change while data is in flight. The stored data is not reloaded, and the new tap appears on the output at once.

The main use is to balance two pipeline paths of unequal latency. A path that is short by N cycles gets a delay line with code N-1. A build-time option puts one flip-flop after the selected tap, which adds one cycle. A cascade output always carries the last stage, so instances can be chained to make delays longer than 16.

Top module: `dyn_shift_line`

## Requirements
- R1: On a rising clock edge with `shift_en` high, stage 0 of every lane captures `din`, and each stage k>0 takes the old value of stage k-1.
- R2: In the combinational output mode, `dout` equals the `din` value applied (code+1) enabled edges earlier. For example, code 4'b0010 gives a delay of 3 enabled edges.
- R3: On an edge with `shift_en` low, no stage and no output register changes, so all outputs keep their values.
- R4: In the combinational output mode, a change of `tap_sel` changes `dout` in the same cycle, with no clock edge needed.
- R5: `chain_out` always carries stage 15, the `din` value from 16 enabled edges earlier, whatever the value of `tap_sel`. If `chain_out` feeds the `din` of a second instance with code s, that instance delays by 16+s+1.
- R6: In the registered output mode, `dout` loads the selected stage on each enabled edge, which gives a delay of code+2 enabled edges.
- R7: While `rst_n` is low, the output register of the registered mode reads zero. The shift stages have no reset and keep their contents through a reset.
- R8: All WIDTH lanes shift together under one `tap_sel` and one `shift_en`, and each lane carries its own data.
- R9: Code 8 gives exactly 9 enabled cycles of delay, which fills a 9-cycle latency gap between two parallel paths.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset. It clears only the optional output register. |
| shift_en | input | 1 | Clock enable for the shift stages and the output register |
| din | input | WIDTH | Serial data in, one bit per lane |
| tap_sel | input | SEL_W (4) | Stage select; delay = code + 1 |
| dout | output | WIDTH | Selected stage, taken straight through or registered |
| chain_out | output | WIDTH | Last stage, used to cascade instances |

## Verification
A stage that captured the wrong data, or that moved on a disabled edge, shows at `dout` only when the tap points at that stage. The bench therefore moves `tap_sel` over every code while the clock enable is off, which exposes each stored stage within a cycle. A wrong cascade stage shows at `chain_out` on the next enabled edge. It also corrupts the chained instance's output up to 16 enabled edges later. A fault in the registered mode shows one enabled edge after the wrong tap is loaded. A reset that also clears the stages shows immediately as a zero on the combinational output during reset.

// File: rtl/dsr_pkg.sv
package dsr_pkg;
  typedef enum logic {
    OUT_COMB = 1'b0,
    OUT_REG  = 1'b1
  } dsr_out_e;

  localparam int DSR_SEL_W_DEFAULT = 4;
  localparam int DSR_WIDTH_DEFAULT = 4;
endpackage

// File: rtl/dsr_stage_chain.sv
module dsr_stage_chain #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      shift_en,
  input  logic [WIDTH-1:0]          din,
  output logic [STAGES*WIDTH-1:0]   stage_bus
);
  logic [WIDTH-1:0] stg_q [STAGES];
  logic [WIDTH-1:0] stg_d [STAGES];

  // Next-state for each stage: its predecessor, stage 0 takes din.
  generate
    for (genvar k = 0; k < STAGES; k++) begin : g_stage
      if (k == 0) begin : g_head
        always_comb stg_d[k] = din;
      end else begin : g_body
        always_comb stg_d[k] = stg_q[k-1];
      end

      // No reset on the storage: contents are defined by flushing.
      always_ff @(posedge clk) begin
        if (shift_en) begin
          stg_q[k] <= stg_d[k];
        end
      end

      assign stage_bus[k*WIDTH +: WIDTH] = stg_q[k];
    end
  endgenerate

  p_shift_in_r1: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> stage_bus[WIDTH-1:0] == $past(din));

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(stage_bus));
endmodule

// File: rtl/dsr_tap_mux.sv
module dsr_tap_mux #(
  parameter int WIDTH = 4,
  parameter int SEL_W = 4,
  localparam int STAGES = 1 << SEL_W
) (
  input  logic [STAGES*WIDTH-1:0] stage_bus,
  input  logic [SEL_W-1:0]        tap_sel,
  output logic [WIDTH-1:0]        tap
);
  // STAGES is a power of two, so every code names a real stage.
  always_comb begin
    tap = stage_bus[int'(tap_sel)*WIDTH +: WIDTH];
  end
endmodule

// File: rtl/dsr_out_reg.sv
module dsr_out_reg #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (load_en) q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end

  p_reg_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> q == $past(d));

  p_reg_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en |=> $stable(q));
endmodule

// File: rtl/dyn_shift_line.sv
module dyn_shift_line #(
  parameter int               WIDTH    = dsr_pkg::DSR_WIDTH_DEFAULT,
  parameter int               SEL_W    = dsr_pkg::DSR_SEL_W_DEFAULT,
  parameter dsr_pkg::dsr_out_e OUT_MODE = dsr_pkg::OUT_COMB,
  localparam int              STAGES   = 1 << SEL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic [WIDTH-1:0] din,
  input  logic [SEL_W-1:0] tap_sel,
  output logic [WIDTH-1:0] dout,
  output logic [WIDTH-1:0] chain_out
);
  logic [STAGES*WIDTH-1:0] stage_bus;
  logic [WIDTH-1:0]        tap;

  dsr_stage_chain #(.WIDTH(WIDTH), .STAGES(STAGES)) u_chain (
    .clk       (clk),
    .rst_n     (rst_n),
    .shift_en  (shift_en),
    .din       (din),
    .stage_bus (stage_bus)
  );

  dsr_tap_mux #(.WIDTH(WIDTH), .SEL_W(SEL_W)) u_mux (
    .stage_bus (stage_bus),
    .tap_sel   (tap_sel),
    .tap       (tap)
  );

  assign chain_out = stage_bus[(STAGES-1)*WIDTH +: WIDTH];

  generate
    if (OUT_MODE == dsr_pkg::OUT_REG) begin : g_reg_out
      dsr_out_reg #(.WIDTH(WIDTH)) u_oreg (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_en (shift_en),
        .d       (tap),
        .q       (dout)
      );
    end else begin : g_comb_out
      assign dout = tap;

      // R2: code 0 means one enabled edge of delay, unless the code moved.
      p_depth0_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && tap_sel == '0) |=> (tap_sel != '0) || (dout == $past(din)));
    end
  endgenerate

  // R5: the cascade port follows the second-to-last stage by one enabled edge.
  p_cascade_r5: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> chain_out == $past(stage_bus[(STAGES-2)*WIDTH +: WIDTH]));
endmodule

// File: tb/dyn_shift_line_bench.sv
`timescale 1ns/1ps
module dyn_shift_line_bench;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         en;
  logic [W-1:0] din;
  logic [3:0]   sel;
  logic [W-1:0] dout_c, chain_c, dout_r, chain_r, dout_t, chain_t;

  int checks = 0;
  int errors = 0;

  logic [W-1:0] hist [32];
  int           pushes = 0;
  logic [W-1:0] exp_reg;
  bit           reg_valid = 1'b0;

  always #4 clk = ~clk;

  dyn_shift_line #(.WIDTH(W)) u_dyn_shift_line (
    .clk(clk), .rst_n(rst_n), .shift_en(en), .din(din), .tap_sel(sel),
    .dout(dout_c), .chain_out(chain_c));

  dyn_shift_line #(.WIDTH(W), .OUT_MODE(dsr_pkg::OUT_REG)) u_dyn_shift_line_reg (
    .clk(clk), .rst_n(rst_n), .shift_en(en), .din(din), .tap_sel(sel),
    .dout(dout_r), .chain_out(chain_r));

  // Second stage of a cascade: input is the first instance's last stage.
  dyn_shift_line #(.WIDTH(W)) u_dyn_shift_line_tail (
    .clk(clk), .rst_n(rst_n), .shift_en(en), .din(chain_c), .tap_sel(sel),
    .dout(dout_t), .chain_out(chain_t));

  function automatic logic [W-1:0] exp_tap(input int idx);
    return hist[idx];
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input logic e, input logic [W-1:0] d, input logic [3:0] s,
                      input string req);
    @(negedge clk);
    en = e; din = d; sel = s;
    #1;
    if (pushes > int'(s))
      chk(dout_c == exp_tap(int'(s)), req, 32'(dout_c), 32'(exp_tap(int'(s))));
    if (pushes > 15) begin
      chk(chain_c == exp_tap(15), "R5", 32'(chain_c), 32'(exp_tap(15)));
      chk(chain_r == exp_tap(15), "R5", 32'(chain_r), 32'(exp_tap(15)));
    end
    if (pushes > 31)
      chk(chain_t == exp_tap(31), "R5", 32'(chain_t), 32'(exp_tap(31)));
    if (pushes > 16 + int'(s))
      chk(dout_t == exp_tap(16 + int'(s)), "R5", 32'(dout_t),
          32'(exp_tap(16 + int'(s))));
    if (reg_valid)
      chk(dout_r == exp_reg, "R6", 32'(dout_r), 32'(exp_reg));
    @(posedge clk);
    if (e) begin
      if (pushes > int'(s)) begin
        exp_reg = hist[int'(s)];
        reg_valid = 1'b1;
      end else begin
        reg_valid = 1'b0;
      end
      for (int k = 31; k > 0; k--) hist[k] = hist[k-1];
      hist[0] = d;
      pushes++;
    end
  endtask

  initial begin
    #1_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd7));
    rst_n = 1'b0; en = 1'b0; din = '0; sel = '0;
    for (int k = 0; k < 32; k++) hist[k] = '0;
    repeat (3) @(negedge clk);
    #1;
    chk(dout_r == '0, "R7", 32'(dout_r), 32'h0);   // reset state
    @(negedge clk);
    rst_n = 1'b1;
    exp_reg = '0; reg_valid = 1'b1;

    // Flush 40 enabled edges of known data (R1, R8: lanes independent).
    for (int i = 0; i < 40; i++)
      step(1'b1, W'($urandom), 4'($urandom), "R1");

    // R2: code 0010 gives a delay of three enabled edges.
    for (int i = 0; i < 6; i++) step(1'b1, W'(i * 5 + 3), 4'd2, "R2");
    // R9: code 8 balances a 9-cycle gap.
    for (int i = 0; i < 12; i++) step(1'b1, W'($urandom), 4'd8, "R9");

    // R3 and R4: enable off, sweep every code; outputs follow code at once.
    for (int s = 0; s < 16; s++) step(1'b0, W'($urandom), 4'(s), "R4");
    for (int i = 0; i < 6; i++) step(1'b0, W'($urandom), 4'd5, "R3");

    // Code 15 and code 0 at the boundaries.
    for (int i = 0; i < 5; i++) step(1'b1, W'($urandom), 4'd15, "R2");
    for (int i = 0; i < 5; i++) step(1'b1, W'($urandom), 4'd0, "R2");

    // R7: reset in mid-run clears only the output register.
    @(negedge clk);
    en = 1'b0; sel = 4'd6; rst_n = 1'b0;
    #1;
    chk(dout_r == '0, "R7", 32'(dout_r), 32'h0);
    chk(dout_c == exp_tap(6), "R7", 32'(dout_c), 32'(exp_tap(6)));
    chk(chain_c == exp_tap(15), "R7", 32'(chain_c), 32'(exp_tap(15)));
    @(negedge clk);
    rst_n = 1'b1;
    exp_reg = '0; reg_valid = 1'b1;
    step(1'b0, W'($urandom), 4'd6, "R7");

    // Constrained random: enable about 3/4 of the time, any code (R8 lanes).
    for (int i = 0; i < 300; i++)
      step(($urandom % 4) != 0, W'($urandom), 4'($urandom), "R8");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule